// File: doc/BRIEF.md
# Handshaked serial result transmitter

This block hands a finished conversion result to an external processor, one bit at a time. When the converter reports the end of a conversion, the block captures a 23-bit count and a sign flag and builds a 24-bit word from them. It pulls the data-valid line low and puts the first bit on the data line in the same cycle. The processor reads the bit and answers with one pulse on the serial clock, low and then high. Each pulse makes the block raise data-valid for one cycle, present the next bit, and lower data-valid again.

The processor's serial clock is asynchronous to the block. It is passed through a synchronizer, and a pulse counts only when the rising edge completes a low-then-high pair. After the last bit, data-valid stays high and the block reports completion with a one-cycle done pulse. If the processor never answers the first bit, the block abandons the transfer after a programmable number of system clocks and reports a timeout. Either report tells the surrounding logic to start the next conversion.

Top module: `hs_result_tx`

## Requirements
- R1: After reset, and whenever no transfer is active, `dv_out` is 1, `dout` is 0 and `done_pulse` is 0.
- R2: The word sent is the count from its bit 22 (first) down to bit 0, followed by the sign as the 24th and last bit. The sign bit is 1 for a positive result and 0 for a negative one.
- R3: A `conv_end` pulse while idle makes `dv_out` 0 on the next cycle, and `dout` carries the first word bit in that same cycle.
- R4: Each counted serial-clock pulse raises `dv_out` at the third system-clock edge after `sclk_in` rises. The next bit is on `dout` in that cycle, and `dv_out` returns to 0 one cycle later with the bit unchanged.
- R5: A rising edge on `sclk_in` that was not preceded by a falling edge during the current transfer does not count, and `dv_out` and `dout` do not change.
- R6: The 24th counted pulse returns `dv_out` to 1 and `dout` to 0 for good. In that same cycle `done_pulse` is 1 for exactly one cycle and `done_timeout` is 0.
- R7: If no pulse is counted on the first bit, `dv_out` returns to 1 exactly `TIMEOUT_CYC` cycles after it fell. In that cycle `done_pulse` and `done_timeout` are both 1.
- R8: The timeout applies only to the first bit. Later bits wait for the processor indefinitely, with `dv_out` held at 0.
- R9: A `conv_end` pulse during a transfer is ignored: the remaining bits still come from the word captured at the start.
- R10: After a completion or a timeout, the next `conv_end` starts a fresh transfer of the newly presented count and sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_end | input | 1 | One-cycle strobe: conversion finished, capture result |
| count_in | input | CNT_W | Conversion count magnitude |
| sign_in | input | 1 | Result sign, 1 = positive, 0 = negative |
| sclk_in | input | 1 | Processor serial clock, asynchronous |
| dv_out | output | 1 | Data valid, active low |
| dout | output | 1 | Serial data bit |
| done_pulse | output | 1 | One-cycle end-of-transfer report |
| done_timeout | output | 1 | With done_pulse: 1 = timed out, 0 = all bits sent |

## Verification
A corrupted shift index or word register shows up as a wrong `dout` at the very next low phase of `dv_out`, within four system clocks of the processor's rising edge. A lost or stale pulse-arming flag shows up in two ways: a missing one-cycle `dv_out` high, or a spurious one after a lone rising edge. Either appears three edges after the edge on `sclk_in`. A timer that is off by a count, or that runs on later bits, moves the `dv_out` rise of the timeout case away from its exact cycle. It can also end a slow transfer early with a done pulse that should not exist.

// File: rtl/hs_result_pkg.sv
package hs_result_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BIT  = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_e;

  // True on the final cycle of a window of 'lim' cycles counted from zero.
  function automatic logic window_end(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt == (lim - 32'd1);
  endfunction

endpackage

// File: rtl/hs_edge_sync.sv
module hs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  // Idle level of the serial clock is high; reset to that to avoid a false fall.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/hs_wait_timer.sv
module hs_wait_timer
  import hs_result_pkg::*;
#(
  parameter int LIMIT = 1_100_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expire = run && window_end(32'(cnt), 32'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (!expire) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/hs_bit_shifter.sv
module hs_bit_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] word_in,
  output logic         head,
  output logic         first,
  output logic         last
);
  localparam int IW = $clog2(W);

  logic [W-1:0]  word;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      idx  <= '0;
    end else if (load) begin
      word <= word_in;
      idx  <= '0;
    end else if (shift) begin
      word <= {word[W-2:0], 1'b0};
      idx  <= idx + IW'(1);
    end
  end

  assign head  = word[W-1];
  assign first = (idx == '0);
  assign last  = (idx == IW'(W - 1));
endmodule

// File: rtl/hs_result_tx.sv
module hs_result_tx
  import hs_result_pkg::*;
#(
  parameter int CNT_W       = 23,
  parameter int TIMEOUT_CYC = 1_100_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_end,
  input  logic [CNT_W-1:0] count_in,
  input  logic             sign_in,
  input  logic             sclk_in,
  output logic             dv_out,
  output logic             dout,
  output logic             done_pulse,
  output logic             done_timeout
);
  localparam int WORD_W = CNT_W + 1;

  function automatic logic [WORD_W-1:0] pack_result(input logic [CNT_W-1:0] c,
                                                    input logic s);
    return {c, s};
  endfunction

  tx_state_e state;
  logic      armed;
  logic      done_r, done_to_r;

  // Named internal events, also observed by the bound checker.
  logic sclk_rise, sclk_fall;
  logic head_bit, first_bit, last_bit;
  logic timer_hit;
  logic st_idle, start_evt, take_evt, expire_evt, finish_evt;

  hs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sclk_in),
    .rise(sclk_rise), .fall(sclk_fall)
  );

  hs_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run((state == ST_BIT) && first_bit),
    .expire(timer_hit)
  );

  hs_bit_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(start_evt),
    .shift(take_evt && !last_bit),
    .word_in(pack_result(count_in, sign_in)),
    .head(head_bit), .first(first_bit), .last(last_bit)
  );

  assign st_idle    = (state == ST_IDLE);
  assign start_evt  = st_idle && conv_end;
  assign take_evt   = (state == ST_BIT) && sclk_rise && armed;
  assign expire_evt = timer_hit && !take_evt;
  assign finish_evt = take_evt && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (start_evt) state <= ST_BIT;
        ST_BIT: begin
          if (finish_evt || expire_evt) state <= ST_IDLE;
          else if (take_evt)            state <= ST_GAP;
        end
        ST_GAP:  state <= ST_BIT;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // A pulse counts only when its rising edge follows a falling edge seen
  // during the current transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b0;
    else if (st_idle)   armed <= 1'b0;
    else if (sclk_fall) armed <= 1'b1;
    else if (take_evt)  armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_r    <= 1'b0;
      done_to_r <= 1'b0;
    end else begin
      done_r    <= finish_evt || expire_evt;
      done_to_r <= expire_evt;
    end
  end

  assign dv_out       = (state != ST_BIT);
  assign dout         = !st_idle && head_bit;
  assign done_pulse   = done_r;
  assign done_timeout = done_to_r;
endmodule

// File: rtl/hs_result_tx_chk.sv
module hs_result_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_end,
  input logic dv_out,
  input logic dout,
  input logic done_pulse,
  input logic done_timeout,
  input logic st_idle,
  input logic take_evt,
  input logic expire_evt,
  input logic last_bit
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> (dv_out && !dout));

  assert_start_drops_dv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && conv_end) |=> !dv_out);

  assert_bit_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && !last_bit) |=> dv_out ##1 !dv_out);

  assert_finish_report_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_evt && last_bit) |=> (dv_out && done_pulse && !done_timeout));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  assert_timeout_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (dv_out && done_pulse && done_timeout));

  assert_busy_strobe_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_idle && !dv_out && conv_end && !take_evt && !expire_evt) |=> !dv_out);
endmodule

bind hs_result_tx hs_result_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_end(conv_end),
  .dv_out(dv_out), .dout(dout), .done_pulse(done_pulse),
  .done_timeout(done_timeout), .st_idle(st_idle),
  .take_evt(take_evt), .expire_evt(expire_evt), .last_bit(last_bit)
);

// File: tb/hs_result_tx_bench.sv
`timescale 1ns/1ps
module hs_result_tx_bench;
  localparam int CNT_W  = 23;
  localparam int WORD_W = 24;
  localparam int T_CYC  = 40;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             conv_end = 1'b0;
  logic [CNT_W-1:0] count_in = '0;
  logic             sign_in = 1'b0;
  logic             sclk_in = 1'b1;
  logic             dv_out, dout, done_pulse, done_timeout;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  hs_result_tx #(.CNT_W(CNT_W), .TIMEOUT_CYC(T_CYC), .SYNC_STAGES(2)) u_hs_result_tx (
    .clk(clk), .rst_n(rst_n), .conv_end(conv_end), .count_in(count_in),
    .sign_in(sign_in), .sclk_in(sclk_in), .dv_out(dv_out), .dout(dout),
    .done_pulse(done_pulse), .done_timeout(done_timeout)
  );

  // Bit i of the serial word: count from its top bit down, sign last.
  function automatic logic word_bit(input logic [CNT_W-1:0] c, input logic s, input int i);
    if (i >= CNT_W) return s;
    return c[CNT_W-1-i];
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic start_conv(input logic [CNT_W-1:0] c, input logic s);
    @(negedge clk);
    count_in = c; sign_in = s; conv_end = 1'b1;
    @(negedge clk);
    conv_end = 1'b0;
  endtask

  // One low-then-high pair; checks the DV gap and the bit that follows.
  task automatic sclk_pulse(input logic exp_next, input bit is_last, input string req);
    @(negedge clk); sclk_in = 1'b0;
    repeat (4) @(negedge clk);
    sclk_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(req, "dv before sync delay ends", dv_out, 0);
    @(negedge clk);
    if (is_last) begin
      chk("R6", "dv after last bit", dv_out, 1);
      chk("R6", "dout after last bit", dout, 0);
      chk("R6", "done_pulse", done_pulse, 1);
      chk("R6", "done_timeout", done_timeout, 0);
      @(negedge clk);
      chk("R6", "done_pulse one cycle", done_pulse, 0);
      chk("R6", "dv stays high", dv_out, 1);
    end else begin
      chk("R4", "dv high gap", dv_out, 1);
      chk(req, "next bit in gap", dout, exp_next);
      @(negedge clk);
      chk("R4", "dv low again", dv_out, 0);
      chk(req, "next bit held", dout, exp_next);
    end
  endtask

  task automatic send_word(input logic [CNT_W-1:0] c, input logic s, input string req);
    start_conv(c, s);
    chk("R3", "dv low after strobe", dv_out, 0);
    chk("R3", "first bit with dv", dout, word_bit(c, s, 0));
    for (int i = 1; i < WORD_W; i++) sclk_pulse(word_bit(c, s, i), 1'b0, req);
    sclk_pulse(1'b0, 1'b1, req);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "dv at reset", dv_out, 1);
    chk("R1", "dout at reset", dout, 0);
    chk("R1", "done at reset", done_pulse, 0);
  endtask

  task automatic t_patterns;
    send_word(23'h5A5A5A, 1'b1, "R2");
    send_word(23'h400001, 1'b0, "R2");
    send_word(23'h7FFFFF, 1'b0, "R2");
  endtask

  task automatic t_timeout;
    start_conv(23'h123456, 1'b1);
    chk("R7", "dv low at start", dv_out, 0);
    repeat (T_CYC - 1) @(negedge clk);
    chk("R7", "dv still low at T-1", dv_out, 0);
    @(negedge clk);
    chk("R7", "dv high at T", dv_out, 1);
    chk("R7", "done_pulse", done_pulse, 1);
    chk("R7", "done_timeout", done_timeout, 1);
    chk("R7", "dout after timeout", dout, 0);
    send_word(23'h0F0F0F, 1'b1, "R10");
  endtask

  task automatic t_slow_later;
    logic [CNT_W-1:0] c = 23'h2AAAAA;
    start_conv(c, 1'b0);
    sclk_pulse(word_bit(c, 1'b0, 1), 1'b0, "R8");
    repeat (3 * T_CYC) @(negedge clk);
    chk("R8", "dv still low after long wait", dv_out, 0);
    chk("R8", "no done after long wait", done_pulse, 0);
    chk("R8", "bit held after long wait", dout, word_bit(c, 1'b0, 1));
    for (int i = 2; i < WORD_W; i++) sclk_pulse(word_bit(c, 1'b0, i), 1'b0, "R8");
    sclk_pulse(1'b0, 1'b1, "R8");
  endtask

  task automatic t_busy_strobe;
    logic [CNT_W-1:0] c = 23'h1C3E07;
    start_conv(c, 1'b1);
    sclk_pulse(word_bit(c, 1'b1, 1), 1'b0, "R9");
    sclk_pulse(word_bit(c, 1'b1, 2), 1'b0, "R9");
    start_conv(~c, 1'b0);
    chk("R9", "dv low after busy strobe", dv_out, 0);
    chk("R9", "bit unchanged after busy strobe", dout, word_bit(c, 1'b1, 2));
    for (int i = 3; i < WORD_W; i++) sclk_pulse(word_bit(c, 1'b1, i), 1'b0, "R9");
    sclk_pulse(1'b0, 1'b1, "R9");
  endtask

  task automatic t_lone_rise;
    logic [CNT_W-1:0] c = 23'h6B1D33;
    bit saw_high = 0;
    @(negedge clk); sclk_in = 1'b0;
    repeat (4) @(negedge clk);
    start_conv(c, 1'b1);
    sclk_in = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (dv_out) saw_high = 1;
    end
    chk("R5", "no dv gap on lone rise", saw_high, 0);
    chk("R5", "first bit kept", dout, word_bit(c, 1'b1, 0));
    for (int i = 1; i < WORD_W; i++) sclk_pulse(word_bit(c, 1'b1, i), 1'b0, "R5");
    sclk_pulse(1'b0, 1'b1, "R5");
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_timeout();
    t_slow_later();
    t_busy_strobe();
    t_lone_rise();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule